// File: doc/BRIEF.md
# Cascadable Display Column Data Loader

This block is the digital front end of a display column driver. On every clock edge while it holds the fill token, it accepts one group of six 6-bit pixel codes. It steers that group into a line register of `NCOLS` columns. Each group covers six adjacent columns. The order in which the groups are filled follows a direction input.

A start pulse arriving on one of two token pins begins a fill. When the last group has been written, a one-cycle pulse leaves on the other pin, where it can start the next device in a chain. The direction input swaps which pin listens and which pin drives, so a chain of devices can be filled from either end.

Each half of the pixel bus has its own control that complements its bits before capture. This lets the sender limit bus toggling. A load strobe copies the line register, complete or not, into a holding register that drives the outputs. The same strobe edge latches a dot-inversion polarity, from which every column gets a positive/negative flag.

Top module: `lcd_col_loader`

## Requirements
- R1: After a clock edge with `rst_n` low, every held code is 0, the latched polarity is 0, the loader is idle and both token outputs are 0.
- R2: With `dir_up_i`=1, a start is a clock edge where `tok_l_i` is 1 and was 0 at the previous edge. The next `NCOLS/6` edges capture groups in ascending order: group g fills columns 6g+1..6g+6, numbering columns from 1.
- R3: With `dir_up_i`=0, a start is taken the same way from `tok_r_i`. The first captured group goes to the highest group (columns NCOLS-5..NCOLS), and later groups descend to columns 1..6.
- R4: Within a group, lane k of `pix_i` (bits 6k+5..6k, bit 6k+5 the MSB) goes to column 6g+k+1, in both directions.
- R5: When `inv_lo_i` is 1, lanes 0..2 are bitwise complemented before capture; when `inv_hi_i` is 1, lanes 3..5 are (e.g. 0x00 becomes 0x3F, 0x07 becomes 0x38).
- R6: The clock edge that captures the last group sets the exit pin's output (`tok_r_o` going up, `tok_l_o` going down) to 1 for exactly one cycle.
- R7: Outside a fill, data is ignored and the line register keeps its contents until a new start is seen.
- R8: A start pin held high for several cycles starts one fill only; a fill is not restarted until the pin has returned low.
- R9: At a clock edge where `load_i` is 1 and was 0 at the previous edge, the line register, as it was before that edge, is copied to the held outputs. Otherwise the held outputs do not change.
- R10: A load strobe during a partial fill transfers whatever the line register holds at that moment.
- R11: The load edge latches `pol_i`. Held polarity 1 flags even-numbered columns positive (`col_pos_o` bit 1) and odd-numbered columns negative; held polarity 0 reverses this. Bit c of `col_pos_o` is column c+1.
- R12: `tok_r_oe` equals `dir_up_i` and `tok_l_oe` equals its complement, so exactly one token pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_up_i | input | 1 | 1: fill ascending, enter left pin; 0: fill descending, enter right pin |
| tok_l_i | input | 1 | Left token pin, input side |
| tok_l_o | output | 1 | Left token pin, output side |
| tok_l_oe | output | 1 | Left token pin drive enable |
| tok_r_i | input | 1 | Right token pin, input side |
| tok_r_o | output | 1 | Right token pin, output side |
| tok_r_oe | output | 1 | Right token pin drive enable |
| pix_i | input | LANES*DW | Six pixel codes, lane k at bits DW*k+DW-1..DW*k |
| inv_lo_i | input | 1 | Complement lanes 0..2 |
| inv_hi_i | input | 1 | Complement lanes 3..5 |
| load_i | input | 1 | Load strobe, acts on its rising edge |
| pol_i | input | 1 | Dot-inversion polarity, latched on load |
| col_code_o | output | NCOLS*DW | Held codes, column c+1 at bits DW*c+DW-1..DW*c |
| col_pos_o | output | NCOLS | Per-column polarity flag, 1 = positive |

## Verification
The bench builds the loader with `NCOLS`=24 and six 6-bit lanes, which gives four groups per line. At that size the end-of-line pulse, the return to idle, a direction reversal and a mid-fill load all occur within a few cycles, and the full held line can be compared on every clock. A behavioural model, fed the same random pixel, inversion, token and load patterns, predicts every column's code, its polarity flag and both token pins.

// File: rtl/lcdcl_pkg.sv
// Package: shared helpers for the column data loader.
// Assumes group count of at least two.
package lcdcl_pkg;

    // Map a fill step to the group it writes, given the fill direction.
    function automatic int unsigned step_to_group(input int unsigned step,
                                                  input logic up,
                                                  input int unsigned ngroups);
        return up ? step : (ngroups - 1 - step);
    endfunction

endpackage

// File: rtl/lcdcl_invert.sv
// Module: per-half bitwise complement of the pixel lanes.
// Lanes below LANES/2 follow inv_lo, the rest follow inv_hi.
// Assumes LANES is even.
module lcdcl_invert #(
    parameter int LANES = 6,
    parameter int DW    = 6
) (
    input  logic [LANES*DW-1:0] pix_i,
    input  logic                inv_lo_i,
    input  logic                inv_hi_i,
    output logic [LANES*DW-1:0] pix_o
);
    localparam int HALF = LANES / 2;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k < HALF) begin : g_lo
            // Lower half: complement under the low control.
            assign pix_o[k*DW +: DW] = pix_i[k*DW +: DW] ^ {DW{inv_lo_i}};
        end else begin : g_hi
            // Upper half: complement under the high control.
            assign pix_o[k*DW +: DW] = pix_i[k*DW +: DW] ^ {DW{inv_hi_i}};
        end
    end
endmodule

// File: rtl/lcdcl_token.sv
// Module: start-token sequencer. Detects a rising start on the
// entry pin chosen by direction, walks NG fill steps, then emits
// a one-cycle exit pulse on the opposite pin.
// Assumes NG >= 2; synchronous active-low reset.
module lcdcl_token #(
    parameter int NG = 67,
    parameter int GW = $clog2(NG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_up_i,
    input  logic          start_l_i,
    input  logic          start_r_i,
    output logic          cap_en_o,
    output logic [GW-1:0] cap_grp_o,
    output logic          end_l_o,
    output logic          end_r_o
);
    import lcdcl_pkg::*;

    localparam logic [GW-1:0] LAST = GW'(NG - 1);

    logic          prev_q, active_q, pulse_q;
    logic [GW-1:0] step_q;
    logic          sel, rise, last;

    // Entry pin selection and rising-start detection.
    always_comb begin
        sel       = dir_up_i ? start_l_i : start_r_i;
        rise      = sel & ~prev_q;
        last      = (step_q == LAST);
        cap_en_o  = active_q & ~rise;
        cap_grp_o = GW'(step_to_group(32'(step_q), dir_up_i, NG));
    end

    // Token state: idle/active, step counter, exit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            active_q <= 1'b0;
            pulse_q  <= 1'b0;
            step_q   <= '0;
        end else begin
            prev_q  <= sel;
            pulse_q <= cap_en_o & last;
            if (rise) begin
                active_q <= 1'b1;
                step_q   <= '0;
            end else if (active_q) begin
                if (last) active_q <= 1'b0;
                else      step_q   <= step_q + 1'b1;
            end
        end
    end

    assign end_r_o = pulse_q & dir_up_i;
    assign end_l_o = pulse_q & ~dir_up_i;

    // R6: exit pulse lasts a single cycle.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    // R2: step counter never leaves the line.
    a_r2_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (step_q <= LAST));
    // R7: idle stays idle until a start is seen.
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !rise) |=> !active_q);
    // R8: a held-high pin does not restart the fill.
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q && sel && active_q && !last) |=> (step_q == $past(step_q) + 1'b1));
endmodule

// File: rtl/lcdcl_line.sv
// Module: line register, holding register and polarity latch.
// Writes one group per capture, copies the line to the hold register
// on a rising load, and derives a per-column polarity flag.
// Assumes load_i is sampled by clk; synchronous active-low reset.
module lcdcl_line #(
    parameter int NCOLS = 402,
    parameter int LANES = 6,
    parameter int DW    = 6,
    parameter int GW    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en_i,
    input  logic [GW-1:0]       cap_grp_i,
    input  logic [LANES*DW-1:0] lanes_i,
    input  logic                load_i,
    input  logic                pol_i,
    output logic [NCOLS*DW-1:0] code_o,
    output logic [NCOLS-1:0]    pos_o
);
    logic [NCOLS-1:0][DW-1:0] line_q, hold_q;
    logic                     pol_q, ld_prev_q;
    logic                     ld_rise;

    assign ld_rise = load_i & ~ld_prev_q;

    // Group capture into the line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (cap_en_i) begin
            for (int c = 0; c < NCOLS; c++) begin
                if (cap_grp_i == GW'(c / LANES))
                    line_q[c] <= lanes_i[(c % LANES)*DW +: DW];
            end
        end
    end

    // Load edge: transfer the line and latch polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            pol_q     <= 1'b0;
            ld_prev_q <= 1'b0;
        end else begin
            ld_prev_q <= load_i;
            if (ld_rise) begin
                hold_q <= line_q;
                pol_q  <= pol_i;
            end
        end
    end

    assign code_o = hold_q;

    for (genvar c = 0; c < NCOLS; c++) begin : g_pol
        // Index c is column c+1: even index = odd-numbered column.
        if (c % 2 == 0) begin : g_oddcol
            assign pos_o[c] = ~pol_q;
        end else begin : g_evencol
            assign pos_o[c] = pol_q;
        end
    end

    // R9: load copies the pre-edge line.
    a_r9_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rise |=> (hold_q == $past(line_q)));
    // R9: without a load edge the outputs hold.
    a_r9_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_rise |=> $stable(hold_q));
    // R7: no capture, no change in the line.
    a_r7_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> $stable(line_q));
    // R11: polarity only moves on a load edge.
    a_r11_pol_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_rise |=> $stable(pol_q));
endmodule

// File: rtl/lcd_col_loader.sv
// Module: top of the cascadable column data loader.
// Combines lane inversion, the token sequencer and the line/hold
// registers. Token pins are split into input, output and enable.
// Assumes NCOLS is a multiple of LANES with at least two groups.
module lcd_col_loader #(
    parameter int NCOLS = 402,
    parameter int LANES = 6,
    parameter int DW    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dir_up_i,
    input  logic                tok_l_i,
    output logic                tok_l_o,
    output logic                tok_l_oe,
    input  logic                tok_r_i,
    output logic                tok_r_o,
    output logic                tok_r_oe,
    input  logic [LANES*DW-1:0] pix_i,
    input  logic                inv_lo_i,
    input  logic                inv_hi_i,
    input  logic                load_i,
    input  logic                pol_i,
    output logic [NCOLS*DW-1:0] col_code_o,
    output logic [NCOLS-1:0]    col_pos_o
);
    localparam int NG = NCOLS / LANES;
    localparam int GW = $clog2(NG);

    logic [LANES*DW-1:0] lanes;
    logic                cap_en;
    logic [GW-1:0]       cap_grp;

    // Drive enables follow the fill direction.
    assign tok_r_oe = dir_up_i;
    assign tok_l_oe = ~dir_up_i;

    lcdcl_invert #(.LANES(LANES), .DW(DW)) inv_i (
        .pix_i(pix_i), .inv_lo_i(inv_lo_i), .inv_hi_i(inv_hi_i), .pix_o(lanes)
    );

    lcdcl_token #(.NG(NG), .GW(GW)) tok_i (
        .clk(clk), .rst_n(rst_n), .dir_up_i(dir_up_i),
        .start_l_i(tok_l_i), .start_r_i(tok_r_i),
        .cap_en_o(cap_en), .cap_grp_o(cap_grp),
        .end_l_o(tok_l_o), .end_r_o(tok_r_o)
    );

    lcdcl_line #(.NCOLS(NCOLS), .LANES(LANES), .DW(DW), .GW(GW)) line_i (
        .clk(clk), .rst_n(rst_n), .cap_en_i(cap_en), .cap_grp_i(cap_grp),
        .lanes_i(lanes), .load_i(load_i), .pol_i(pol_i),
        .code_o(col_code_o), .pos_o(col_pos_o)
    );

    // R12: exactly one token pin is driven.
    a_r12_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({tok_l_oe, tok_r_oe}));
    // R6: a token output only pulses on the driven pin.
    a_r6_pulse_on_driver: assert property (@(posedge clk) disable iff (!rst_n)
        ((tok_l_o -> tok_l_oe) && (tok_r_o -> tok_r_oe)));
endmodule

// File: tb/lcd_col_loader_tb.sv
// Bench: behavioural reference model compared on every clock.
module lcd_col_loader_tb_top;
    localparam int  NCOLS = 24;
    localparam int  LANES = 6;
    localparam int  DW    = 6;
    localparam int  NG    = NCOLS / LANES;
    localparam time TCLK  = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_up_i = 1'b1, tok_l_i = 1'b0, tok_r_i = 1'b0;
    logic inv_lo_i = 1'b0, inv_hi_i = 1'b0, load_i = 1'b0, pol_i = 1'b0;
    logic [LANES*DW-1:0] pix_i = '0;
    logic tok_l_o, tok_l_oe, tok_r_o, tok_r_oe;
    logic [NCOLS*DW-1:0] col_code_o;
    logic [NCOLS-1:0]    col_pos_o;

    int    vectors = 0, miscompares = 0;
    bit    done = 1'b0, rand_pix = 1'b1, rand_inv = 1'b0;
    string cur = "R1";

    always #(TCLK/2) clk = ~clk;

    lcd_col_loader #(.NCOLS(NCOLS), .LANES(LANES), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .dir_up_i(dir_up_i),
        .tok_l_i(tok_l_i), .tok_l_o(tok_l_o), .tok_l_oe(tok_l_oe),
        .tok_r_i(tok_r_i), .tok_r_o(tok_r_o), .tok_r_oe(tok_r_oe),
        .pix_i(pix_i), .inv_lo_i(inv_lo_i), .inv_hi_i(inv_hi_i),
        .load_i(load_i), .pol_i(pol_i),
        .col_code_o(col_code_o), .col_pos_o(col_pos_o)
    );

    // Reference model state.
    int ref_line[NCOLS];
    int ref_hold[NCOLS];
    bit ref_pol, ref_act, ref_pulse, ref_sprev, ref_lprev;
    int ref_step;

    always @(posedge clk) begin
        bit sel, newp;
        int g, v;
        if (!rst_n) begin
            foreach (ref_line[c]) begin ref_line[c] = 0; ref_hold[c] = 0; end
            ref_pol = 0; ref_act = 0; ref_pulse = 0;
            ref_sprev = 0; ref_lprev = 0; ref_step = 0;
        end else begin
            sel = dir_up_i ? tok_l_i : tok_r_i;
            if (load_i && !ref_lprev) begin
                foreach (ref_line[c]) ref_hold[c] = ref_line[c];
                ref_pol = pol_i;
            end
            newp = 0;
            if (sel && !ref_sprev) begin
                ref_act = 1; ref_step = 0;
            end else if (ref_act) begin
                g = dir_up_i ? ref_step : NG - 1 - ref_step;
                for (int k = 0; k < LANES; k++) begin
                    v = int'(pix_i[k*DW +: DW]);
                    if ((k < LANES/2) ? inv_lo_i : inv_hi_i) v = v ^ 63;
                    ref_line[g*LANES + k] = v;
                end
                if (ref_step == NG - 1) begin ref_act = 0; newp = 1; end
                else ref_step++;
            end
            ref_pulse = newp;
            ref_sprev = sel;
            ref_lprev = load_i;
        end
    end

    // Full-state comparison against the model, one vector per clock.
    task automatic compare_all();
        bit bad = 0;
        vectors++;
        for (int c = 0; c < NCOLS; c++) begin
            bit ep = ref_pol ? (c % 2 == 1) : (c % 2 == 0);
            if (!bad && int'(col_code_o[c*DW +: DW]) != ref_hold[c]) begin
                $display("FAIL %s col %0d code: actual %0d expected %0d", cur, c+1,
                         col_code_o[c*DW +: DW], ref_hold[c]);
                bad = 1;
            end
            if (!bad && col_pos_o[c] != ep) begin
                $display("FAIL %s col %0d pos: actual %0b expected %0b", cur, c+1,
                         col_pos_o[c], ep);
                bad = 1;
            end
        end
        if (tok_r_o != (dir_up_i & ref_pulse) || tok_l_o != (!dir_up_i & ref_pulse)) begin
            $display("FAIL %s token out l/r: actual %0b%0b expected %0b%0b", cur,
                     tok_l_o, tok_r_o, !dir_up_i & ref_pulse, dir_up_i & ref_pulse);
            bad = 1;
        end
        if (tok_r_oe != dir_up_i || tok_l_oe != !dir_up_i) begin
            $display("FAIL R12 oe l/r: actual %0b%0b expected %0b%0b",
                     tok_l_oe, tok_r_oe, !dir_up_i, dir_up_i);
            bad = 1;
        end
        if (bad) miscompares++;
    endtask

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: compare after the edge, then refresh random inputs.
    task automatic tick();
        @(negedge clk);
        compare_all();
        if (rand_pix) pix_i = LANES*DW'($urandom);
        if (rand_inv) begin inv_lo_i = 1'($urandom); inv_hi_i = 1'($urandom); end
    endtask

    task automatic start(bit up, int width);
        dir_up_i = up;
        if (up) tok_l_i = 1; else tok_r_i = 1;
        repeat (width) tick();
        tok_l_i = 0; tok_r_i = 0;
    endtask

    task automatic do_load(bit p);
        load_i = 1; pol_i = p;
        tick();
        load_i = 0;
        tick();
    endtask

    initial begin
        int pulses;
        // R1: reset state.
        cur = "R1";
        repeat (3) tick();
        chk("R1 code col1", int'(col_code_o[0 +: DW]), 0);
        chk("R1 pos col1", int'(col_pos_o[0]), 1);
        chk("R1 tok_r_o", int'(tok_r_o), 0);
        rst_n = 1;
        tick();

        // R2 / R6: ascending fill, count exit pulses.
        cur = "R2";
        start(1, 1);
        pulses = 0;
        for (int i = 0; i < NG + 3; i++) begin
            tick();
            if (tok_r_o) pulses++;
        end
        chk("R6 exit pulse count", pulses, 1);
        chk("R12 right oe when up", int'(tok_r_oe), 1);
        cur = "R9";
        do_load(1);
        chk("R11 pos col2 pol1", int'(col_pos_o[1]), 1);
        chk("R11 pos col1 pol1", int'(col_pos_o[0]), 0);

        // R3 / R4: descending fill with fixed lanes k+10.
        cur = "R3";
        rand_pix = 0;
        for (int k = 0; k < LANES; k++) pix_i[k*DW +: DW] = DW'(k + 10);
        start(0, 1);
        repeat (NG + 2) tick();
        chk("R12 left oe when down", int'(tok_l_oe), 1);
        cur = "R4";
        do_load(0);
        chk("R4 col1 lane0", int'(col_code_o[0 +: DW]), 10);
        chk("R4 col24 lane5", int'(col_code_o[23*DW +: DW]), 15);
        chk("R11 pos col1 pol0", int'(col_pos_o[0]), 1);

        // R5: zero data with low half inverted.
        cur = "R5";
        pix_i = '0; inv_lo_i = 1; inv_hi_i = 0;
        start(1, 1);
        repeat (NG + 1) tick();
        do_load(1);
        chk("R5 col1 inverted", int'(col_code_o[0 +: DW]), 63);
        chk("R5 col4 not inverted", int'(col_code_o[3*DW +: DW]), 0);
        inv_lo_i = 0;

        // R5: random inversion, both directions.
        rand_pix = 1; rand_inv = 1;
        start(0, 1);
        repeat (NG + 1) tick();
        do_load(0);
        start(1, 1);
        repeat (NG + 1) tick();
        do_load(1);
        rand_inv = 0; inv_lo_i = 0; inv_hi_i = 0;

        // R8: wide start pulses.
        cur = "R8";
        start(1, 3);
        repeat (NG) tick();
        do_load(0);
        start(0, NG + 2);
        repeat (3) tick();
        do_load(1);

        // R7: data while idle is ignored.
        cur = "R7";
        repeat (12) tick();
        do_load(0);

        // R10: load during a partial fill.
        cur = "R10";
        start(1, 1);
        repeat (2) tick();
        do_load(1);
        repeat (NG) tick();
        do_load(0);

        // R11: repeated polarity loads.
        cur = "R11";
        do_load(1);
        do_load(0);
        repeat (4) tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule